// File: doc/BRIEF.md
# NAND Flash Block-Erase Sequencer

This block takes an 8-bit NAND flash device through a complete block erase with no help from software beyond a single start pulse. On start it latches a block row address, turns the chip select on, and walks a fixed script of bus operations. Each operation targets one of three memory-mapped windows. A write to the command window raises the command latch enable. A write to the address window raises the address latch enable. Reads of the data window raise neither.

The script writes the erase setup command, then the three row bytes with the least significant byte first, then the erase confirm command. After that it writes the status command once. It then reads the status byte from the data window over and over until the device reports ready. The final status decides the pass/fail result, which is presented with a one-cycle done pulse. A timing engine shapes every bus operation. Write strobes last a programmable number of clocks while the data is held steady. Read data is captured on the same clock edge that raises the read strobe.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, chip select, write enable and read enable (all active low) are high. Both latch enables, busy and done are low.
- R2: The first bus write of an erase is the command byte 0x60, written to the command window (command latch high, address latch low).
- R3: The next three writes go to the address window (address latch high, command latch low) and carry row bits [7:0], then [15:8], then [23:16].
- R4: After the row bytes, the block writes 0xD0 to the command window, then writes 0x70 to the command window exactly once. The erase makes six writes in total.
- R5: Status reads use the data window, with both latch enables low. The erase ends at the first status read that returns bit 6 = 1 (ready) while the ready/busy input is high. Until then the read is repeated.
- R6: When done pulses, fail equals bit 0 of that final status byte. Fail holds this value until the next accepted start.
- R7: Done is a single-cycle pulse. Busy is high from the cycle after an accepted start up to and including the done cycle, and low in the cycle after it.
- R8: Each write strobe stays low for exactly `we_width_i` clocks, or 1 clock when `we_width_i` is 0. The data bus does not change while the strobe is low.
- R9: A start pulse during an erase is ignored. The running erase keeps its row address and issues no extra commands.
- R10: Chip select is low throughout an erase and high when idle. The write and read strobes are never low together, and are never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that requests a block erase |
| row_i | input | 24 | Block row address, latched on an accepted start |
| we_width_i | input | 4 | Write strobe low time in clocks (0 means 1) |
| nand_rb_i | input | 1 | Device ready/busy, high when ready |
| nand_ce_n_o | output | 1 | Chip select, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_io | inout | 8 | Bidirectional data bus |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Erase failure flag from the final status |

## Verification
Suppose the sequencer holds a wrong step or a wrong row-byte index. The error shows at the latch enables and the data bus on the next write strobe edge, at most a few strobe widths after start. A wrong poll decision shows as a read count that differs from the one implied by the device model's ready point and ready/busy release, and done then arrives early or late. A broken strobe counter shows on every write as a low time that differs from the programmed width, before the erase gets past its first command.

// File: rtl/nes_pkg.sv
package nes_pkg;

    localparam logic [15:0] OFS_DATA = 16'h0000;
    localparam logic [15:0] OFS_CMD  = 16'h1000;
    localparam logic [15:0] OFS_ADDR = 16'h2000;

    localparam logic [7:0] CMD_ERASE_SETUP   = 8'h60;
    localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_STATUS        = 8'h70;

    localparam logic [7:0] STAT_READY_MASK = 8'h40;
    localparam logic [7:0] STAT_FAIL_MASK  = 8'h01;

    typedef struct packed {
        logic        wr;
        logic [15:0] ofs;
        logic [7:0]  data;
    } bus_op_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SETUP,
        E_STROBE,
        E_HOLD
    } eng_st_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_SETUP,
        C_ADDR,
        C_CONFIRM,
        C_STAT_CMD,
        C_POLL,
        C_FINISH
    } ctl_st_e;

endpackage

// File: rtl/nes_win_decode.sv
module nes_win_decode
    import nes_pkg::*;
(
    input  logic        active_i,
    input  logic [15:0] ofs_i,
    output logic        cle_o,
    output logic        ale_o
);
    always_comb begin
        cle_o = active_i && (ofs_i == OFS_CMD);
        ale_o = active_i && (ofs_i == OFS_ADDR);
    end
endmodule

// File: rtl/nes_cycle_engine.sv
module nes_cycle_engine
    import nes_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  bus_op_t          op_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic [7:0]       dq_in_i,
    output logic             ack_o,
    output logic [7:0]       rd_data_o,
    output logic             active_o,
    output logic [15:0]      ofs_o,
    output logic             we_n_o,
    output logic             re_n_o,
    output logic             dq_oe_o,
    output logic [7:0]       dq_out_o
);
    typedef struct packed {
        eng_st_e          st;
        logic [CNT_W-1:0] cnt;
        bus_op_t          op;
        logic [7:0]       rdat;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d     = q;
        ack_o = 1'b0;
        unique case (q.st)
            E_IDLE: begin
                if (req_i) begin
                    d.st = E_SETUP;
                    d.op = op_i;
                end
            end
            E_SETUP: begin
                d.st  = E_STROBE;
                d.cnt = (width_i == '0) ? CNT_W'(1) : width_i;
            end
            E_STROBE: begin
                d.cnt = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1)) begin
                    d.st = E_HOLD;
                    if (!q.op.wr) begin
                        d.rdat = dq_in_i;
                    end
                end
            end
            E_HOLD: begin
                ack_o = 1'b1;
                d.st  = E_IDLE;
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: E_IDLE, cnt: '0, op: '0, rdat: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data_o = q.rdat;
        active_o  = (q.st != E_IDLE);
        ofs_o     = q.op.ofs;
        we_n_o    = !((q.st == E_STROBE) && q.op.wr);
        re_n_o    = !((q.st == E_STROBE) && !q.op.wr);
        dq_oe_o   = (q.st != E_IDLE) && q.op.wr;
        dq_out_o  = q.op.data;
    end
endmodule

// File: rtl/nes_erase_ctrl.sv
module nes_erase_ctrl
    import nes_pkg::*;
#(
    parameter int ROW_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [8*ROW_BYTES-1:0] row_i,
    input  logic                   rb_i,
    input  logic                   ack_i,
    input  logic [7:0]             rd_i,
    output logic                   req_o,
    output bus_op_t                op_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   fail_o
);
    localparam int ROW_W = 8 * ROW_BYTES;
    localparam int IDX_W = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROW_BYTES - 1);

    typedef struct packed {
        ctl_st_e          st;
        logic             issued;
        logic [IDX_W-1:0] idx;
        logic [ROW_W-1:0] row;
        logic             fail;
    } ctl_t;

    ctl_t q, d;
    logic stat_ready;
    logic stat_fail;

    always_comb begin
        stat_ready = (rd_i & STAT_READY_MASK) != '0;
        stat_fail  = (rd_i & STAT_FAIL_MASK) != '0;
    end

    always_comb begin
        d     = q;
        req_o = 1'b0;
        op_o  = '0;
        unique case (q.st)
            C_SETUP:    op_o = '{wr: 1'b1, ofs: OFS_CMD,  data: CMD_ERASE_SETUP};
            C_ADDR:     op_o = '{wr: 1'b1, ofs: OFS_ADDR, data: q.row[q.idx*8 +: 8]};
            C_CONFIRM:  op_o = '{wr: 1'b1, ofs: OFS_CMD,  data: CMD_ERASE_CONFIRM};
            C_STAT_CMD: op_o = '{wr: 1'b1, ofs: OFS_CMD,  data: CMD_STATUS};
            C_POLL:     op_o = '{wr: 1'b0, ofs: OFS_DATA, data: 8'h00};
            default:    op_o = '0;
        endcase

        if (q.st inside {C_SETUP, C_ADDR, C_CONFIRM, C_STAT_CMD, C_POLL}) begin
            if (!q.issued) begin
                req_o    = 1'b1;
                d.issued = 1'b1;
            end
            if (ack_i) begin
                d.issued = 1'b0;
            end
        end

        unique case (q.st)
            C_IDLE: begin
                if (start_i) begin
                    d.st     = C_SETUP;
                    d.row    = row_i;
                    d.fail   = 1'b0;
                    d.idx    = '0;
                    d.issued = 1'b0;
                end
            end
            C_SETUP:    if (ack_i) d.st = C_ADDR;
            C_ADDR: begin
                if (ack_i) begin
                    if (q.idx == IDX_LAST) begin
                        d.st = C_CONFIRM;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            C_CONFIRM:  if (ack_i) d.st = C_STAT_CMD;
            C_STAT_CMD: if (ack_i) d.st = C_POLL;
            C_POLL: begin
                if (ack_i && stat_ready && rb_i) begin
                    d.fail = stat_fail;
                    d.st   = C_FINISH;
                end
            end
            C_FINISH:   d.st = C_IDLE;
            default:    d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: C_IDLE, issued: 1'b0, idx: '0, row: '0, fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy_o = (q.st != C_IDLE);
        done_o = (q.st == C_FINISH);
        fail_o = q.fail;
    end
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nes_pkg::*;
#(
    parameter int ROW_BYTES = 3,
    parameter int CNT_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [8*ROW_BYTES-1:0] row_i,
    input  logic [CNT_W-1:0]       we_width_i,
    input  logic                   nand_rb_i,
    output logic                   nand_ce_n_o,
    output logic                   nand_cle_o,
    output logic                   nand_ale_o,
    output logic                   nand_we_n_o,
    output logic                   nand_re_n_o,
    inout  wire  [7:0]             nand_dq_io,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   fail_o
);
    logic        req;
    bus_op_t     op;
    logic        ack;
    logic [7:0]  rd_data;
    logic        active;
    logic [15:0] ofs;
    logic        dq_oe;
    logic [7:0]  dq_out;
    logic        busy;

    nes_erase_ctrl #(.ROW_BYTES(ROW_BYTES)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .row_i  (row_i),
        .rb_i   (nand_rb_i),
        .ack_i  (ack),
        .rd_i   (rd_data),
        .req_o  (req),
        .op_o   (op),
        .busy_o (busy),
        .done_o (done_o),
        .fail_o (fail_o)
    );

    nes_cycle_engine #(.CNT_W(CNT_W)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .op_i     (op),
        .width_i  (we_width_i),
        .dq_in_i  (nand_dq_io),
        .ack_o    (ack),
        .rd_data_o(rd_data),
        .active_o (active),
        .ofs_o    (ofs),
        .we_n_o   (nand_we_n_o),
        .re_n_o   (nand_re_n_o),
        .dq_oe_o  (dq_oe),
        .dq_out_o (dq_out)
    );

    nes_win_decode dec_i (
        .active_i(active),
        .ofs_i   (ofs),
        .cle_o   (nand_cle_o),
        .ale_o   (nand_ale_o)
    );

    assign nand_dq_io  = dq_oe ? dq_out : 8'hzz;
    assign nand_ce_n_o = !busy;
    assign busy_o      = busy;
endmodule

// File: rtl/nes_chk.sv
module nes_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       fail,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] dq
);
    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R10
    strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    dq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(dq));

    // R6
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(fail));
endmodule

bind nand_erase_seq nes_chk chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start_i),
    .busy (busy_o),
    .done (done_o),
    .fail (fail_o),
    .ce_n (nand_ce_n_o),
    .cle  (nand_cle_o),
    .ale  (nand_ale_o),
    .we_n (nand_we_n_o),
    .re_n (nand_re_n_o),
    .dq   (nand_dq_io)
);

// File: tb/nand_erase_seq_tb_top.sv
module nand_erase_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] row = '0;
    logic [3:0]  wid = 4'd1;
    logic        rb;
    logic        ce_n, cle, ale, we_n, re_n, busy, done, fail;
    wire  [7:0]  dq;

    int n_chk = 0;
    int n_bad = 0;

    // device model state
    logic [9:0] wlog [16];
    int  wlog_n = 0;
    int  reads = 0;
    int  rdy_after = 0;
    int  rb_after = 0;
    logic fail_bit = 1'b0;
    logic confirm_seen = 1'b0;
    int  lowcnt = 0;
    int  exp_w = 1;
    int  width_bad = 0;
    int  dq_chg = 0;
    logic [7:0] status;

    always #2 clk = ~clk;

    nand_erase_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .row_i      (row),
        .we_width_i (wid),
        .nand_rb_i  (rb),
        .nand_ce_n_o(ce_n),
        .nand_cle_o (cle),
        .nand_ale_o (ale),
        .nand_we_n_o(we_n),
        .nand_re_n_o(re_n),
        .nand_dq_io (dq),
        .busy_o     (busy),
        .done_o     (done),
        .fail_o     (fail)
    );

    assign status = (reads >= rdy_after) ? (8'h40 | {7'd0, fail_bit}) : 8'h00;
    assign rb     = !confirm_seen || (reads >= rb_after);
    assign dq     = !re_n ? status : 8'hzz;

    always @(posedge we_n) begin
        if (wlog_n < 16) wlog[wlog_n] = {cle, ale, dq};
        wlog_n = wlog_n + 1;
        if (cle && dq == 8'hD0) confirm_seen = 1'b1;
        if (lowcnt != exp_w) width_bad = width_bad + 1;
        lowcnt = 0;
    end
    always @(posedge re_n) reads = reads + 1;
    always @(negedge clk) if (!we_n) lowcnt = lowcnt + 1;
    always @(dq) if (!we_n) dq_chg = dq_chg + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // vector: {row[36:13], width[12:9], ready_after[8:5], rb_after[4:1], fail[0]}
    localparam logic [36:0] VEC [6] = '{
        {24'h0A0B0C, 4'd1,  4'd0, 4'd0, 1'b0},
        {24'h123456, 4'd3,  4'd2, 4'd1, 1'b1},
        {24'hFFFFFF, 4'd0,  4'd1, 4'd3, 1'b0},
        {24'h000001, 4'd15, 4'd4, 4'd0, 1'b1},
        {24'h80FF00, 4'd2,  4'd0, 4'd5, 1'b0},
        {24'hC3A55A, 4'd5,  4'd6, 4'd6, 1'b1}
    };

    task automatic run_erase(input logic [23:0] r, input logic [3:0] w, input int rdy,
                             input int rbl, input logic fb, input bit restart);
        int exp_reads;
        int busy_viol = 0;
        int cyc = 0;
        bit seen = 0;
        wlog_n = 0; reads = 0; confirm_seen = 1'b0; width_bad = 0; dq_chg = 0;
        rdy_after = rdy; rb_after = rbl; fail_bit = fb;
        exp_w = (w == 0) ? 1 : int'(w);
        exp_reads = (rdy + 1 > rbl) ? rdy + 1 : rbl;
        @(negedge clk); row = r; wid = w; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!seen && cyc < 3000) begin
            if (restart && cyc == 8) begin start = 1'b1; row = ~r; end
            else start = 1'b0;
            if (done) begin
                seen = 1;
                chk(busy, "R7 busy in done cycle", busy, 1);
                chk(fail == fb, "R6 fail at done", fail, fb);
            end else begin
                if (!busy || ce_n) busy_viol = busy_viol + 1;
            end
            cyc = cyc + 1;
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen, "R5 done reached", seen, 1);
        chk(busy_viol == 0, "R10 ce/busy during erase", busy_viol, 0);
        chk(!busy && !done && ce_n, "R7 idle after done", {busy, done, ce_n}, 1);
        chk(wlog_n == 6, "R4/R9 write count", wlog_n, 6);
        chk(wlog[0] == {2'b10, 8'h60}, "R2 setup command", wlog[0], {2'b10, 8'h60});
        chk(wlog[1] == {2'b01, r[7:0]},   "R3 row byte 0", wlog[1], {2'b01, r[7:0]});
        chk(wlog[2] == {2'b01, r[15:8]},  "R3 row byte 1", wlog[2], {2'b01, r[15:8]});
        chk(wlog[3] == {2'b01, r[23:16]}, "R3 row byte 2", wlog[3], {2'b01, r[23:16]});
        chk(wlog[4] == {2'b10, 8'hD0}, "R4 confirm command", wlog[4], {2'b10, 8'hD0});
        chk(wlog[5] == {2'b10, 8'h70}, "R4 status command", wlog[5], {2'b10, 8'h70});
        chk(reads == exp_reads, "R5 status read count", reads, exp_reads);
        chk(width_bad == 0, "R8 strobe width", width_bad, 0);
        chk(dq_chg == 0, "R8 data steady under strobe", dq_chg, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad = n_bad + 1;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_n && we_n && re_n, "R1 strobes idle in reset", {ce_n, we_n, re_n}, 7);
        chk(!cle && !ale && !busy && !done, "R1 flags low in reset", {cle, ale, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ce_n && we_n && re_n && !busy, "R1 idle after reset", {ce_n, we_n, re_n, busy}, 4'hE);

        for (int i = 0; i < 6; i++) begin
            run_erase(VEC[i][36:13], VEC[i][12:9], int'(VEC[i][8:5]),
                      int'(VEC[i][4:1]), VEC[i][0], 1'b0);
        end

        // R9: start during erase ignored (row and command count unchanged)
        run_erase(24'h5A5A01, 4'd2, 3, 2, 1'b0, 1'b1);

        // R6: fail held while idle after a failing erase
        run_erase(24'h010203, 4'd1, 1, 1, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk(fail == 1'b1, "R6 fail held while idle", fail, 1);
        // cleared by next accepted start
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(fail == 1'b0 && busy, "R6 fail cleared on start", fail, 0);
        repeat (200) @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule